// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives a stereo serial audio stream as a slave. The bit clock, frame clock and serial data arrive from an external source. The block samples them with the local system clock, re-times them and turns the stream into parallel left and right sample words. Each word is at most 24 bits. Each channel has a one-cycle strobe that marks when its word is ready. A two-bit format input selects one of four framings: left-justified, I2S, right-justified and DSP (frame-pulse). A two-bit length input sets the word length for right-justified and DSP framing.

Samples are two's complement and are sent MSB first. Each output word is left-aligned in its 24-bit field, so a short sample keeps its full-scale meaning. A sequencer with four states tracks each channel slot:

- HUNT waits for the first slot boundary after reset.
- LEAD counts the leading filler bits of a right-justified half frame.
- TAKE writes incoming bits into the word under construction.
- DRAIN ignores the rest of a slot.

Transitions:

- A slot boundary moves HUNT, TAKE or DRAIN to TAKE in left-justified, I2S and DSP framing, and to LEAD in right-justified framing.
- LEAD moves to TAKE when the filler count reaches the data start.
- TAKE moves to DRAIN after the final bit of a word. In DSP framing, TAKE stays in TAKE and switches to the right channel after the left word.

Top module: `audio_serial_rx`

## Requirements
- R1: Words are captured MSB first, two's complement. In every format the first word after a slot/frame start that is assigned to the left channel is reported on the left outputs, and the other word on the right outputs.
- R2: With `fmt_sel`=00 (left-justified), a slot starts at each change of `lrck_in`. High selects left. The bit sampled on the first `bclk_in` rising edge after the change is the MSB.
- R3: With `fmt_sel`=01 (I2S), a slot starts at each change of `lrck_in`. Low selects left. The bit on the first rising edge of the slot is ignored and the MSB follows on the next rising edge.
- R4: With `fmt_sel`=10 (right-justified), `lrck_in` high selects left and each half frame holds 32 bit clocks. The word occupies the last L bits of the half. `wlen_sel` gives L: 00→24 (reset-default value of the field), 01→20, 10→16, 11→24. The word therefore starts 8, 12 or 16 bits after the edge.
- R5: With `fmt_sel`=11 (DSP), a rising edge of `lrck_in` marks a frame. The MSB of the left word is sampled on that same edge. The right word follows the left word's LSB directly. Both words are L bits long, with L taken from `wlen_sel`.
- R6: In left-justified and I2S framing, bits beyond the 24th bit of a slot are discarded and do not change the word.
- R7: A word shorter than 24 bits is placed in the upper bits of its output, and the unused low bits read zero.
- R8: In left-justified and I2S framing, a word is reported at the start of the next slot. In right-justified and DSP framing, a word is reported after its final bit, without waiting for the frame clock. Each strobe lasts one `clk` cycle, and the two strobes are never high together.
- R9: In DSP framing, a frame edge that arrives before the right word is complete discards the partial word and restarts with a left word.
- R10: Only rising edges of `bclk_in` advance the receiver, so bursts and pauses of any length in the bit clock are accepted.
- R11: After reset both strobes are low and both words are zero. The first slot boundary after reset reports nothing.
- R12: Each output word holds its value between strobes of its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| lrck_in | input | 1 | Frame / channel clock (asynchronous) |
| sdata_in | input | 1 | Serial sample data |
| fmt_sel | input | 2 | Framing: 00 left-justified, 01 I2S, 10 right-justified, 11 DSP |
| wlen_sel | input | 2 | Word length: 00 24, 01 20, 10 16, 11 24 bits |
| left_word | output | SAMPLE_W | Last complete left sample, left-aligned |
| right_word | output | SAMPLE_W | Last complete right sample, left-aligned |
| left_strobe | output | 1 | One-cycle pulse when left_word is updated |
| right_strobe | output | 1 | One-cycle pulse when right_word is updated |

## Verification
The hardest case to reach from the ports is a DSP frame edge that cuts off a right word part-way through. If the receiver failed to restart, it would merge the stale bits with the next frame. The bench sends a left word and five bits of a right word, then a fresh frame pulse, and expects only the next complete left and right words. The bench also pads slots with ones in the positions that must be ignored. It stretches the bit clock with long pauses in one left-justified frame, and checks that a left-justified word is held back until the following frame-clock change.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LEAD,
        ST_TAKE,
        ST_DRAIN
    } rx_state_e;

    // word length selected by the two-bit length code; spare code means 24
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 20;
            2'b10:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrck,
    input  logic sdata,
    output logic rise,
    output logic lr,
    output logic sd
);
    logic [STAGES:0]   bq;
    logic [STAGES-1:0] lq;
    logic [STAGES-1:0] dq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bq <= '0;
            lq <= '0;
            dq <= '0;
        end else begin
            bq <= {bq[STAGES-1:0], bclk};
            lq <= {lq[STAGES-2:0], lrck};
            dq <= {dq[STAGES-2:0], sdata};
        end
    end

    assign rise = bq[STAGES-1] & ~bq[STAGES];
    assign lr   = lq[STAGES-1];
    assign sd   = dq[STAGES-1];
endmodule

// File: rtl/srx_word.sv
module srx_word #(
    parameter int W  = 24,
    parameter int IW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic          din,
    output logic [W-1:0]  q,
    output logic [W-1:0]  merged
);
    logic [W-1:0] nxt;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic hit;
        assign hit        = (idx == IW'(W - 1 - gi));
        assign merged[gi] = hit ? din : q[gi];
        assign nxt[gi]    = (we && hit) ? din : (clr ? 1'b0 : q[gi]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import srx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int HALF_BITS = 32,
    parameter int SYNC_STG  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                lrck_in,
    input  logic                sdata_in,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                left_strobe,
    output logic                right_strobe
);
    localparam int IW = $clog2(SAMPLE_W + 1);
    localparam int CW = $clog2(HALF_BITS);
    localparam logic [IW-1:0] IDX_LIM  = IW'(SAMPLE_W);
    localparam logic [IW-1:0] IDX_LAST = IW'(SAMPLE_W - 1);

    logic bit_rise, lr, sd;

    srx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk(bclk_in), .lrck(lrck_in), .sdata(sdata_in),
        .rise(bit_rise), .lr(lr), .sd(sd)
    );

    rx_state_e     st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [CW-1:0] pos_q, pos_d;
    logic          ch_q, ch_d;      // 1 = left
    logic          busy_q, busy_d;  // a left-/I2S-justified word awaits its report
    logic          seen_q, lr_prev_q;

    logic          clr, we, emit, emit_left, use_merged;
    logic [IW-1:0] widx;
    logic [SAMPLE_W-1:0] word_q, word_m;

    srx_word #(.W(SAMPLE_W), .IW(IW)) u_word (
        .clk(clk), .rst_n(rst_n), .clr(clr), .we(we), .idx(widx), .din(sd),
        .q(word_q), .merged(word_m)
    );

    fmt_e          fmt;
    logic [IW-1:0] wl;
    logic [CW-1:0] lead;
    logic          start;

    assign fmt   = fmt_e'(fmt_sel);
    assign wl    = IW'(word_bits(wlen_sel));
    assign lead  = CW'(HALF_BITS - word_bits(wlen_sel));
    assign start = (fmt == FMT_DSP) ? (seen_q && lr && !lr_prev_q)
                                    : (seen_q && (lr != lr_prev_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_HUNT;
            idx_q     <= '0;
            pos_q     <= '0;
            ch_q      <= 1'b0;
            busy_q    <= 1'b0;
            seen_q    <= 1'b0;
            lr_prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            pos_q  <= pos_d;
            ch_q   <= ch_d;
            busy_q <= busy_d;
            if (bit_rise) begin
                seen_q    <= 1'b1;
                lr_prev_q <= lr;
            end
        end
    end

    // next state and capture control
    always_comb begin
        st_d       = st_q;
        idx_d      = idx_q;
        pos_d      = pos_q;
        ch_d       = ch_q;
        busy_d     = busy_q;
        clr        = 1'b0;
        we         = 1'b0;
        widx       = idx_q;
        emit       = 1'b0;
        emit_left  = ch_q;
        use_merged = 1'b0;
        if (bit_rise) begin
            if (start) begin
                clr = 1'b1;
                unique case (fmt)
                    FMT_LJ, FMT_I2S: begin
                        emit   = busy_q;
                        busy_d = 1'b1;
                        ch_d   = (fmt == FMT_LJ) ? lr : !lr;
                        st_d   = ST_TAKE;
                        if (fmt == FMT_LJ) begin
                            we    = 1'b1;
                            widx  = '0;
                            idx_d = IW'(1);
                        end else begin
                            idx_d = '0;
                        end
                    end
                    FMT_RJ: begin
                        busy_d = 1'b0;
                        ch_d   = lr;
                        pos_d  = CW'(1);
                        st_d   = ST_LEAD;
                    end
                    FMT_DSP: begin
                        busy_d = 1'b0;
                        ch_d   = 1'b1;
                        we     = 1'b1;
                        widx   = '0;
                        idx_d  = IW'(1);
                        st_d   = ST_TAKE;
                    end
                endcase
            end else begin
                unique case (st_q)
                    ST_HUNT, ST_DRAIN: begin
                    end
                    ST_LEAD: begin
                        if (pos_q == lead) begin
                            we    = 1'b1;
                            widx  = '0;
                            idx_d = IW'(1);
                            st_d  = ST_TAKE;
                        end else begin
                            pos_d = pos_q + CW'(1);
                        end
                    end
                    ST_TAKE: begin
                        if (idx_q < IDX_LIM) begin
                            we    = 1'b1;
                            idx_d = idx_q + IW'(1);
                        end
                        if (fmt == FMT_RJ || fmt == FMT_DSP) begin
                            if (idx_q == wl - IW'(1)) begin
                                emit       = 1'b1;
                                use_merged = 1'b1;
                                if (fmt == FMT_DSP && ch_q) begin
                                    ch_d  = 1'b0;
                                    idx_d = '0;
                                    clr   = 1'b1;
                                    we    = 1'b0;
                                end else begin
                                    st_d = ST_DRAIN;
                                end
                            end
                        end else if (idx_q == IDX_LAST) begin
                            st_d = ST_DRAIN;
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_word    <= '0;
            right_word   <= '0;
            left_strobe  <= 1'b0;
            right_strobe <= 1'b0;
        end else begin
            left_strobe  <= emit && emit_left;
            right_strobe <= emit && !emit_left;
            if (emit && emit_left)  left_word  <= use_merged ? word_m : word_q;
            if (emit && !emit_left) right_word <= use_merged ? word_m : word_q;
        end
    end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_rise,
    input logic [1:0]   fmt_sel,
    input logic [1:0]   wlen_sel,
    input logic [W-1:0] left_word,
    input logic [W-1:0] right_word,
    input logic         left_strobe,
    input logic         right_strobe
);
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_strobe && right_strobe)); // R8
    AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        left_strobe |=> !left_strobe); // R8
    AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        right_strobe |=> !right_strobe); // R8
    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (left_strobe || right_strobe) |-> $past(bit_rise)); // R10
    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_strobe |-> $stable(left_word)); // R12
    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !right_strobe |-> $stable(right_word)); // R12
    AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (left_strobe && fmt_sel == 2'b10 && wlen_sel == 2'b10) |-> (left_word[W-17:0] == '0)); // R7
endmodule

bind audio_serial_rx srx_checker #(.W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .left_word(left_word), .right_word(right_word),
    .left_strobe(left_strobe), .right_strobe(right_strobe)
);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [1:0] fmt = 2'b00, wlen = 2'b00;
    logic [23:0] lw, rw;
    logic ls, rs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        left;
        logic [23:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    audio_serial_rx uut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrck_in(lrck), .sdata_in(sdata),
        .fmt_sel(fmt), .wlen_sel(wlen), .left_word(lw), .right_word(rw),
        .left_strobe(ls), .right_strobe(rs)
    );

    function automatic logic [23:0] top_mask(input int n);
        return (n >= 24) ? 24'hFFFFFF : ~(24'hFFFFFF >> n);
    endfunction

    function automatic int len_of(input logic [1:0] c);
        return (c == 2'b01) ? 20 : (c == 2'b10) ? 16 : 24;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // monitor: pops the scoreboard as strobes appear
    always @(negedge clk) begin
        if (rst_n && (ls || rs)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected strobe", ls ? lw : rw, 24'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.left == ls, e.tag, "channel", {23'h0, ls}, {23'h0, e.left});
                check((ls ? lw : rw) == e.val, e.tag, "word", ls ? lw : rw, e.val);
            end
        end
    end

    task automatic push(input logic left, input logic [23:0] v, input string tag);
        exp_t e;
        e.left = left; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bit_out(input logic l, input logic d, input int gap);
        @(negedge clk);
        bclk = 1'b0; lrck = l; sdata = d;
        repeat (4 + gap) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
        @(negedge clk);
        rst_n = 1'b0; fmt = f; wlen = w; bclk = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic lj_slot(input logic left, input logic [23:0] v, input int n, input int gap, input string tag);
        push(left, v & top_mask(n), tag);
        for (int i = 0; i < n; i++) bit_out(left, (i < 24) ? v[23 - i] : 1'b1, gap);
    endtask

    task automatic i2s_slot(input logic left, input logic [23:0] v, input int n, input string tag);
        push(left, v & top_mask(n), tag);
        bit_out(!left, 1'b1, 0);
        for (int i = 0; i < n; i++) bit_out(!left, (i < 24) ? v[23 - i] : 1'b1, 0);
    endtask

    task automatic rj_half(input logic left, input logic [23:0] v, input string tag);
        int wl;
        wl = len_of(wlen);
        push(left, v & top_mask(wl), tag);
        for (int i = 0; i < 32; i++)
            bit_out(left, (i < 32 - wl) ? 1'b1 : v[23 - (i - (32 - wl))], 0);
    endtask

    task automatic dsp_word(input logic [23:0] v, input int n, input bit first);
        for (int i = 0; i < n; i++) bit_out(first && i == 0, v[23 - i], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ls == 1'b0 && rs == 1'b0, "R11", "strobes in reset", {22'h0, ls, rs}, 24'h0);
        check(lw == 24'h0 && rw == 24'h0, "R11", "words in reset", lw | rw, 24'h0);

        // left-justified
        do_reset(2'b00, 2'b00);
        bit_out(1'b0, 1'b0, 0); bit_out(1'b0, 1'b1, 0);
        lj_slot(1'b1, 24'h9A5C3E, 32, 0, "R2");
        check(sb.size() == 1, "R8", "left held until next slot", 24'(sb.size()), 24'd1);
        lj_slot(1'b0, 24'h13579B, 32, 0, "R6");
        check(sb.size() == 1, "R8", "left reported at slot change", 24'(sb.size()), 24'd1);
        lj_slot(1'b1, 24'hF0F0F0, 16, 9, "R10");
        lj_slot(1'b0, 24'h7ABCDE, 20, 0, "R7");
        bit_out(1'b1, 1'b0, 0);
        repeat (8) @(negedge clk);

        // I2S
        do_reset(2'b01, 2'b00);
        bit_out(1'b1, 1'b0, 0); bit_out(1'b1, 1'b0, 0);
        i2s_slot(1'b1, 24'h812345, 31, "R3");
        i2s_slot(1'b0, 24'h6C6C6C, 24, "R3");
        i2s_slot(1'b1, 24'hC3A5FF, 18, "R7");
        i2s_slot(1'b0, 24'h0F1E2D, 28, "R6");
        bit_out(1'b0, 1'b0, 0);
        repeat (8) @(negedge clk);

        // right-justified, all length codes
        do_reset(2'b10, 2'b00);
        bit_out(1'b0, 1'b0, 0); bit_out(1'b0, 1'b0, 0);
        for (int c = 0; c < 4; c++) begin
            wlen = 2'(c);
            rj_half(1'b1, 24'hA1B2C3 ^ 24'(c * 24'h111111), "R4");
            rj_half(1'b0, 24'h5E6F70 ^ 24'(c * 24'h0F0F0F), "R4");
            repeat (4) @(negedge clk);
            check(sb.size() == 0, "R8", "right-justified word reported after last bit", 24'(sb.size()), 24'd0);
        end

        // DSP
        do_reset(2'b11, 2'b00);
        bit_out(1'b0, 1'b0, 0); bit_out(1'b0, 1'b0, 0);
        push(1'b1, 24'hDEAD12, "R5"); push(1'b0, 24'h4B3C2D, "R5");
        dsp_word(24'hDEAD12, 24, 1'b1); dsp_word(24'h4B3C2D, 24, 1'b0);
        for (int i = 0; i < 16; i++) bit_out(1'b0, 1'b1, 0);
        wlen = 2'b10;
        push(1'b1, 24'h8ACE00, "R5"); push(1'b0, 24'h135700, "R7");
        dsp_word(24'h8ACE55, 16, 1'b1); dsp_word(24'h1357AA, 16, 1'b0);
        for (int i = 0; i < 8; i++) bit_out(1'b0, 1'b1, 0);
        push(1'b1, 24'hFEDC00, "R9");
        dsp_word(24'hFEDCFF, 16, 1'b1); dsp_word(24'hFFFFFF, 5, 1'b0);
        push(1'b1, 24'h246800, "R9"); push(1'b0, 24'h975300, "R9");
        dsp_word(24'h2468FF, 16, 1'b1); dsp_word(24'h9753FF, 16, 1'b0);
        repeat (8) @(negedge clk);

        check(sb.size() == 0, "R1", "all expected words reported", 24'(sb.size()), 24'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule